// File: doc/BRIEF.md
# I2C Bus Master with Register-Sequenced Clock Holding

This block is an I2C bus controller that software drives through four byte-wide registers: a control register, two status registers and a data register. It leaves reset as a passive slave-side observer that watches the bus for Start and Stop conditions. Writing the start bit while the bus is idle moves it into master mode. It then puts a Start condition on the bus and shifts out a 7-bit address byte, or a 10-bit address split into a header byte and a second byte. After that it shifts out data bytes and, on request, ends the transfer with a Stop condition.

Each protocol stage ends in an event: start sent, header sent, address sent, or byte finished. The event sets its own status flag and the common event bit, and raises the interrupt output when enabled. The block then holds SCL low until software performs a specific pair of register accesses: a read of status register 1 followed by a write to either the data register or the control register. SCL and SDA are open-drain, with separate drive-low outputs and sampled inputs. A parameter sets the SCL half-period in system clocks.

Register addresses are CTRL=0, SR1=1, SR2=2, DATA=3. CTRL bits: [0] start (write action, reads 0), [1] stop, [2] interrupt enable, [3] 10-bit mode. SR1 bits: [0] start sent, [1] address sent, [2] header sent, [3] byte finished, [5] master, [7] event (OR of bits 0..3), others 0. SR2 bits: [0] acknowledge failure, [1] bus busy, others 0.

Top module: `i2c_evmaster`

## Requirements
- R1: After reset, both drive-low outputs and irq are 0, and CTRL, SR1 and SR2 all read 0x00. While SR1 bit 5 (master) is 0, the block never drives SCL or SDA low.
- R2: A CTRL write with bit 0 set while SR2 bit 1 (busy) is 0 sets the master bit and pulls SDA low while SCL is high. The block then pulls SCL low and sets SR1 start-sent and event, so SR1 reads 0xA1.
- R3: A CTRL write with bit 0 set while busy is 1 has no effect. The lines stay released and SR1 stays 0x00.
- R4: After a start-sent event, SCL stays low until an SR1 read is followed by a DATA write. A DATA write with no SR1 read before it does not release SCL. The written byte is the first address byte.
- R5: In 7-bit mode exactly one address byte is shifted out, MSB first, on 8 SCL pulses, with acknowledge sampled on the ninth pulse. SR1 then reads 0xA2 and only one event flag is ever set at a time.
- R6: In 10-bit mode (CTRL bit 3) the first byte is the header. After it, SR1 reads 0xA4 and SCL stays low until an SR1 read plus a DATA write supply the second address byte. After the second byte, SR1 reads 0xA2.
- R7: After the address event, SCL stays low until an SR1 read is followed by a CTRL write. That sets byte-finished (SR1 0xA8). An SR1 read plus a DATA write then shifts one data byte, after which SR1 again reads 0xA8.
- R8: While byte-finished is set, a CTRL write with bit 1 set, followed by a CTRL write with bit 1 clear, generates a Stop: SDA rises while SCL is high. Both lines are then released and the master bit returns to 0. The first write alone keeps SCL held.
- R9: A high SDA on the ninth pulse sets SR2 bit 0. A read of SR2 clears it. This flag does not hold SCL: SCL is held low whenever any event flag is set, and the next byte still clocks while the flag is set.
- R10: irq is 1 exactly when CTRL bit 2 is 1 and the SR1 event bit is 1.
- R11: Busy is set when the bus shows a Start (SDA falls while SCL is high) and cleared on a Stop (SDA rises while SCL is high). This holds whether or not this block made the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (status reads have side effects) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |

## Verification
A wrong sequencing state shows at the ports within one system clock. SCL either keeps toggling when it should be held, or stays low after the required status read and register write. In either case SR1 then reads a flag pattern other than the single event expected. A shift or bit-count fault appears within one byte time (18 SCL half-periods) as a wrong byte captured by the slave responder, or as an acknowledge failure reported in the wrong place. A bus-monitor fault appears as a wrong busy bit on the first SR2 read after a Start or Stop.

// File: rtl/i2c_evmaster_pkg.sv
package i2c_evmaster_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SR1  = 2'd1;
  localparam logic [1:0] A_SR2  = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  localparam int C_START = 0;
  localparam int C_STOP  = 1;
  localparam int C_ITE   = 2;
  localparam int C_TEN   = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_STA, S_WSB, S_BLO, S_BHI, S_WHDR, S_WADR, S_WBTF, S_STP1, S_STP2
  } state_t;

  typedef enum logic [1:0] {K_HDR, K_ADR, K_DAT} kind_t;

  typedef struct packed {
    logic timerRun;
    logic load;
    logic shift;
    logic dataWr;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_evmaster_dp.sv
module i2c_evmaster_dp
  import i2c_evmaster_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              tick,
  output logic              shMsb,
  output logic              lastBit,
  output logic              busy,
  output logic [BYTE_W-1:0] dataReg
);
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [TW-1:0]     timer;
  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              sclQ, sdaQ;

  assign tick    = st.timerRun && (timer == TW'(HALF_CYC - 1));
  assign shMsb   = shReg[BYTE_W-1];
  assign lastBit = (bitCnt == CNT_W'(BYTE_W));

  // half-period timer, parked at zero outside timed states
  always_ff @(posedge clk) begin
    if (!rstN || !st.timerRun || tick) timer <= '0;
    else                               timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (st.load) begin
      shReg  <= wdata;
      bitCnt <= '0;
    end else if (st.shift) begin
      shReg  <= {shReg[BYTE_W-2:0], 1'b0};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          dataReg <= '0;
    else if (st.dataWr) dataReg <= wdata;
  end

  // bus condition monitor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      busy <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (sclIn && sclQ && sdaQ && !sdaIn)      busy <= 1'b1;
      else if (sclIn && sclQ && !sdaQ && sdaIn) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evmaster_ctrl.sv
module i2c_evmaster_ctrl
  import i2c_evmaster_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [3:0]        ctrlBits,
  input  logic              sdaIn,
  input  logic              tick,
  input  logic              shMsb,
  input  logic              lastBit,
  input  logic              busy,
  input  logic [BYTE_W-1:0] dataReg,
  output dpStrobe_t         st,
  output logic [BYTE_W-1:0] regRdata,
  output logic              irq,
  output logic              sclLow,
  output logic              sdaLow,
  output logic [3:0]        evtFlags,
  output logic              master
);
  state_t state;
  kind_t  kind;
  logic sb, hdr, adr, btf, af, ite, ten, stopBit, stopPend, srSeen;
  logic wrCtrl, wrData, rdSr1, rdSr2, waitState, evf;
  logic relSb, relHdr, relAdr, relBtf, stopGo;

  assign wrCtrl    = regWr && regAddr == A_CTRL;
  assign wrData    = regWr && regAddr == A_DATA;
  assign rdSr1     = regRd && regAddr == A_SR1;
  assign rdSr2     = regRd && regAddr == A_SR2;
  assign waitState = state inside {S_WSB, S_WHDR, S_WADR, S_WBTF};
  assign evf       = sb | hdr | adr | btf;
  assign evtFlags  = {btf, hdr, adr, sb};
  assign irq       = ite & evf;

  assign relSb  = state == S_WSB  && srSeen && wrData;
  assign relHdr = state == S_WHDR && srSeen && wrData;
  assign relAdr = state == S_WADR && srSeen && wrCtrl;
  assign relBtf = state == S_WBTF && srSeen && wrData;
  assign stopGo = state == S_WBTF && wrCtrl && !ctrlBits[C_STOP] && stopPend;

  always_comb begin
    st          = '0;
    st.timerRun = state inside {S_STA, S_BLO, S_BHI, S_STP1, S_STP2};
    st.load     = relSb | relHdr | relBtf;
    st.shift    = state == S_BHI && tick && !lastBit;
    st.dataWr   = wrData;
  end

  // line drives decoded from state
  always_comb begin
    sclLow = !(state inside {S_IDLE, S_STA, S_BHI, S_STP2});
    case (state)
      S_STA, S_WSB, S_STP1, S_STP2: sdaLow = 1'b1;
      S_BLO, S_BHI:                 sdaLow = !lastBit && !shMsb;
      default:                      sdaLow = 1'b0;
    endcase
  end

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdata = {4'b0, ten, ite, stopBit, 1'b0};
      A_SR1:   regRdata = {evf, 1'b0, master, 1'b0, btf, hdr, adr, sb};
      A_SR2:   regRdata = {6'b0, busy, af};
      default: regRdata = dataReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; kind <= K_ADR;
      {sb, hdr, adr, btf, af, ite, ten, stopBit, stopPend, srSeen, master} <= '0;
    end else begin
      if (wrCtrl) begin
        ite     <= ctrlBits[C_ITE];
        ten     <= ctrlBits[C_TEN];
        stopBit <= ctrlBits[C_STOP];
      end
      if (rdSr1 && waitState) srSeen <= 1'b1;
      if (rdSr2)              af     <= 1'b0;
      case (state)
        S_IDLE: if (wrCtrl && ctrlBits[C_START] && !busy) begin
          master <= 1'b1; state <= S_STA;
        end
        S_STA: if (tick) begin sb <= 1'b1; state <= S_WSB; end
        S_WSB: if (relSb) begin
          sb <= 1'b0; srSeen <= 1'b0; kind <= ten ? K_HDR : K_ADR; state <= S_BLO;
        end
        S_BLO: if (tick) state <= S_BHI;
        S_BHI: if (tick) begin
          if (lastBit) begin
            if (sdaIn) af <= 1'b1;
            case (kind)
              K_HDR:   begin hdr <= 1'b1; state <= S_WHDR; end
              K_ADR:   begin adr <= 1'b1; state <= S_WADR; end
              default: begin btf <= 1'b1; state <= S_WBTF; end
            endcase
          end else state <= S_BLO;
        end
        S_WHDR: if (relHdr) begin
          hdr <= 1'b0; srSeen <= 1'b0; kind <= K_ADR; state <= S_BLO;
        end
        S_WADR: if (relAdr) begin
          adr <= 1'b0; btf <= 1'b1; srSeen <= 1'b0; state <= S_WBTF;
        end
        S_WBTF: begin
          if (relBtf) begin
            btf <= 1'b0; srSeen <= 1'b0; kind <= K_DAT; state <= S_BLO;
          end else if (stopGo) begin
            btf <= 1'b0; srSeen <= 1'b0; stopPend <= 1'b0; state <= S_STP1;
          end else if (wrCtrl && ctrlBits[C_STOP]) stopPend <= 1'b1;
        end
        S_STP1: if (tick) state <= S_STP2;
        S_STP2: if (tick) begin master <= 1'b0; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_evmaster.sv
module i2c_evmaster
  import i2c_evmaster_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow
);
  dpStrobe_t         st;
  logic              tick, shMsb, lastBit, busy, master;
  logic [BYTE_W-1:0] dataReg;
  logic [3:0]        evtFlags;

  i2c_evmaster_dp #(.HALF_CYC(HALF_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wdata(regWdata), .sclIn(sclIn),
    .sdaIn(sdaIn), .tick(tick), .shMsb(shMsb), .lastBit(lastBit),
    .busy(busy), .dataReg(dataReg)
  );

  i2c_evmaster_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .ctrlBits(regWdata[3:0]), .sdaIn(sdaIn), .tick(tick), .shMsb(shMsb),
    .lastBit(lastBit), .busy(busy), .dataReg(dataReg), .st(st),
    .regRdata(regRdata), .irq(irq), .sclLow(sclDriveLow), .sdaLow(sdaDriveLow),
    .evtFlags(evtFlags), .master(master)
  );
endmodule

// File: rtl/i2c_evmaster_chk.sv
module i2c_evmaster_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regAddr,
  input logic       regWr,
  input logic       sclDriveLow,
  input logic       sdaDriveLow,
  input logic       irq,
  input logic [3:0] evtFlags,
  input logic       master,
  input logic       busy
);
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !master |-> (!sclDriveLow && !sdaDriveLow)); // R1
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(master) |-> !$past(busy)); // R2
  AST_SB_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(evtFlags[0]) |-> $past(regWr && regAddr == 2'd3)); // R4
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evtFlags)); // R5
  AST_ADR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(evtFlags[1]) |-> $past(regWr && regAddr == 2'd0)); // R7
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (|evtFlags) |-> sclDriveLow); // R9
  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|evtFlags)); // R10
endmodule

bind i2c_evmaster i2c_evmaster_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
  .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .irq(irq),
  .evtFlags(evtFlags), .master(master), .busy(busy)
);

// File: tb/i2c_evmaster_test.sv
`timescale 1ns/1ps
module i2c_evmaster_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic irq, sclDriveLow, sdaDriveLow, sclIn, sdaIn;
  logic slaveSdaLow = 1'b0, extSdaLow = 1'b0, nackNext = 1'b0;
  logic startSeen = 1'b0, stopSeen = 1'b0;
  logic [7:0] slvSh = '0;
  logic [7:0] rxBytes [0:15];
  int slvCnt = 0, rxN = 0, checks = 0, errors = 0, cycles = 0;

  assign sclIn = !sclDriveLow;
  assign sdaIn = !(sdaDriveLow || slaveSdaLow || extSdaLow);

  i2c_evmaster uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sclIn(sclIn),
    .sdaIn(sdaIn), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  always #2.5 clk = ~clk;

  // slave responder
  always @(negedge sdaIn) if (sclIn) begin startSeen = 1'b1; slvCnt = 0; slaveSdaLow = 1'b0; end
  always @(posedge sdaIn) if (sclIn) stopSeen = 1'b1;
  always @(posedge sclIn) begin
    if (slvCnt < 8) slvSh = {slvSh[6:0], sdaIn};
    slvCnt++;
    if (slvCnt == 8 && rxN < 16) begin rxBytes[rxN] = slvSh; rxN++; end
  end
  always @(negedge sclIn) begin
    if (slvCnt == 8) slaveSdaLow = !nackNext;
    else if (slvCnt == 9) begin slaveSdaLow = 1'b0; slvCnt = 0; end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    chkEq(req, irq, 1);
  endtask

  task automatic holdLow(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (!sclDriveLow) bad++; end
    chkEq(req, bad, 0);
  endtask

  task automatic doStop(input logic [7:0] base, input string req);
    logic [7:0] v;
    stopSeen = 1'b0;
    regWrite(2'd0, base | 8'h02);
    holdLow(10, {req, " stop set alone keeps hold"});
    regWrite(2'd0, base);
    repeat (30) @(negedge clk);
    chkEq({req, " stop condition seen"}, stopSeen, 1);
    chkEq({req, " lines released"}, {sclDriveLow, sdaDriveLow}, 0);
    regRead(2'd1, v); chkEq({req, " SR1 after stop"}, v, 8'h00);
    regRead(2'd2, v); chkEq("R11 busy cleared by stop", v, 8'h00);
  endtask

  task automatic testReset();
    logic [7:0] v;
    chkEq("R1 lines released", {sclDriveLow, sdaDriveLow}, 0);
    chkEq("R1 irq low", irq, 0);
    regRead(2'd0, v); chkEq("R1 CTRL", v, 0);
    regRead(2'd1, v); chkEq("R1 SR1", v, 0);
    regRead(2'd2, v); chkEq("R1 SR2", v, 0);
  endtask

  task automatic testSevenBit();
    logic [7:0] v;
    rxN = 0; startSeen = 1'b0;
    regWrite(2'd0, 8'h04);
    chkEq("R10 irq idle", irq, 0);
    regWrite(2'd0, 8'h05);
    waitIrq("R2 start event");
    chkEq("R2 start on bus", startSeen, 1);
    regWrite(2'd3, 8'h5A);
    holdLow(40, "R4 data write without status read");
    regRead(2'd1, v); chkEq("R2 SR1 start sent", v, 8'hA1);
    regRead(2'd2, v); chkEq("R11 busy after own start", v, 8'h02);
    regWrite(2'd3, 8'hA4);
    waitIrq("R5 address event");
    chkEq("R5 one byte shifted", rxN, 1);
    chkEq("R5 address bits", rxBytes[0], 8'hA4);
    regRead(2'd1, v); chkEq("R5 SR1 address sent", v, 8'hA2);
    holdLow(40, "R7 hold after address until control write");
    regWrite(2'd0, 8'h04);
    regRead(2'd1, v); chkEq("R7 SR1 byte finished", v, 8'hA8);
    regWrite(2'd3, 8'h3C);
    waitIrq("R7 data event");
    chkEq("R7 data bits", rxBytes[1], 8'h3C);
    regRead(2'd1, v); chkEq("R7 SR1 after data", v, 8'hA8);
    doStop(8'h04, "R8");
  endtask

  task automatic testBusyStart();
    logic [7:0] v;
    extSdaLow = 1'b1;
    repeat (5) @(negedge clk);
    regRead(2'd2, v); chkEq("R11 foreign start sets busy", v, 8'h02);
    regWrite(2'd0, 8'h01);
    repeat (20) @(negedge clk);
    chkEq("R3 no drive while busy", {sclDriveLow, sdaDriveLow}, 0);
    regRead(2'd1, v); chkEq("R3 SR1 unchanged", v, 8'h00);
    extSdaLow = 1'b0;
    repeat (5) @(negedge clk);
    regRead(2'd2, v); chkEq("R11 foreign stop clears busy", v, 8'h00);
  endtask

  task automatic testTenBit();
    logic [7:0] v;
    int n;
    rxN = 0;
    regWrite(2'd0, 8'h0C);
    regWrite(2'd0, 8'h0D);
    waitIrq("R2 start event 10-bit");
    regRead(2'd1, v); chkEq("R2 SR1 start sent 10-bit", v, 8'hA1);
    regWrite(2'd3, 8'hF2);
    waitIrq("R6 header event");
    regRead(2'd1, v); chkEq("R6 SR1 header sent", v, 8'hA4);
    chkEq("R6 header bits", rxBytes[0], 8'hF2);
    holdLow(40, "R6 hold after header");
    nackNext = 1'b1;
    regWrite(2'd3, 8'h5B);
    waitIrq("R6 second address event");
    nackNext = 1'b0;
    chkEq("R6 second address bits", rxBytes[1], 8'h5B);
    regRead(2'd1, v); chkEq("R6 SR1 address sent", v, 8'hA2);
    regWrite(2'd0, 8'h0C);
    regRead(2'd1, v); chkEq("R7 SR1 byte finished 10-bit", v, 8'hA8);
    regWrite(2'd0, 8'h08);
    chkEq("R10 irq masked", irq, 0);
    regWrite(2'd0, 8'h0C);
    chkEq("R10 irq enabled", irq, 1);
    regWrite(2'd3, 8'h81);
    n = 0;
    while (sclDriveLow && n < 20) begin @(negedge clk); n++; end
    chkEq("R9 failure flag does not hold SCL", sclDriveLow, 0);
    waitIrq("R9 data event");
    chkEq("R9 data bits", rxBytes[2], 8'h81);
    regRead(2'd2, v); chkEq("R9 ack failure set", v, 8'h03);
    regRead(2'd2, v); chkEq("R9 ack failure cleared by read", v, 8'h02);
    doStop(8'h0C, "R8 10-bit");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSevenBit();
    testBusyStart();
    testTenBit();
    report();
  end
endmodule